// File: doc/BRIEF.md
# Bit-Band Alias Bridge

The bridge sits between a bus master and a byte-addressable memory. It maps a 32 MB alias window so that every 32-bit alias word stands for exactly one bit of the underlying memory. A read of an alias word fetches the containing data and returns that single bit in bit 0. A write of an alias word becomes a read-modify-write on the underlying memory. The read-modify-write sets or clears the one bit and leaves every neighbouring bit as it was.

The slave side has a simple valid/ready request channel and a one-cycle response pulse. The master side issues one request at a time and holds it until the memory returns a response. The underlying region base is a parameter. The default value places alias `0x2200_0000` on top of `0x2000_0000`. A second instance with base `0x4000_0000` covers the peripheral alias at `0x4200_0000`. The access size is coded as 0 = 1 byte, 1 = 2 bytes and 2 = 4 bytes. It sets both the alignment of the memory access and the span of the bit index. Data on the memory port is little-endian: byte k of the access, counted from the lowest address, sits in bits [8k+7:8k].

Top module: `bitband_bridge`

## Requirements
- R1: For alias address A and size code s (0, 1 or 2), the memory access uses the address (BASE_ADDR | A[24:5]) with its low s bits cleared, and mem_size_o = s. Address bits above bit 24 are ignored.
- R2: The selected bit index is A[6:2] masked to 3, 4 or 5 bits for s = 0, 1 or 2. It addresses bit (index mod 8) of byte (index div 8) of the little-endian access data, so every size reaches the same physical bit.
- R3: A successful read responds with rsp_err_o = 0 and rsp_rdata_o equal to the selected bit, with bits 31..1 at zero.
- R4: A write issues one memory read and then one memory write of the same address and size. The written data equals the fetched data with only the selected bit changed, set when req_wdata_i[0] = 1 and cleared otherwise. The other bits of req_wdata_i have no effect. A write responds with rsp_rdata_o = 0.
- R5: The write response is raised only after the memory has completed the write-back.
- R6: If the memory read returns an error, the bridge responds with rsp_err_o = 1 and rsp_rdata_o = 0 and performs no write-back.
- R7: req_ready_o is high only when the bridge is idle. It drops from the cycle after a request is accepted until the response pulse has passed. mem_req_o stays high and stable until mem_rvalid_i.
- R8: A request with size code 3 responds with rsp_err_o = 1 and does not touch the memory.
- R9: After reset, req_ready_o = 1, mem_req_o = 0 and rsp_valid_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Alias request valid |
| req_ready_o | output | 1 | Bridge idle, request accepted when both high |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Alias address (low 25 bits used) |
| req_size_i | input | 2 | Access size code 0/1/2 = 1/2/4 bytes |
| req_wdata_i | input | DATA_W | Write data, only bit 0 used |
| rsp_valid_o | output | 1 | One-cycle response pulse |
| rsp_err_o | output | 1 | Response error |
| rsp_rdata_o | output | DATA_W | Read result, bit 0 only |
| mem_req_o | output | 1 | Memory request, held until mem_rvalid_i |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | ADDR_W | Memory byte address, size aligned |
| mem_size_o | output | 2 | Memory access size code |
| mem_wdata_o | output | DATA_W | Memory write data, little-endian |
| mem_rvalid_i | input | 1 | Memory response for the held request |
| mem_err_i | input | 1 | Memory response error |
| mem_rdata_i | input | DATA_W | Memory read data, little-endian |

## Verification
The bench builds the bridge with its default parameters: a 32-bit address and data path, the 25-bit window and base `0x2000_0000`. It backs the memory port with a 64-byte model that answers every request after a fixed delay. At that size every bit of the first 16 underlying bytes can be read and then written back at all three access sizes. This exercises each alignment and every bit-index mask against arithmetic expectations, and it shows that the bits next to the target stay untouched. It also covers the top of the window and alias addresses that carry bits above the window. A flag in the memory model turns its read responses into errors, which brings the abort path within reach.

// File: rtl/bb_pkg.sv
package bb_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_STORE, ST_RESP} bb_state_e;

  function automatic logic size_valid(input logic [1:0] s);
    return s != 2'd3;
  endfunction
endpackage

// File: rtl/bb_addr_map.sv
module bb_addr_map import bb_pkg::*; #(
  parameter int unsigned ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h2000_0000,
  parameter int unsigned WIN_W = 25,
  parameter int unsigned IDX_W = 5
) (
  input  logic [ADDR_W-1:0] alias_i,
  input  logic [1:0]        size_i,
  output logic [ADDR_W-1:0] phys_o,
  output logic [IDX_W-1:0]  bit_idx_o,
  output logic              size_ok_o
);
  // 32 alias bytes per underlying byte
  localparam int unsigned SHIFT = 5;

  logic [ADDR_W-1:0] byte_addr, align_mask;
  logic [IDX_W-1:0]  idx_mask;

  always_comb begin
    byte_addr = BASE_ADDR | ADDR_W'(alias_i[WIN_W-1:SHIFT]);
    unique case (size_i)
      2'd0:    begin align_mask = '1;             idx_mask = IDX_W'(7);  end
      2'd1:    begin align_mask = ~ADDR_W'(1);    idx_mask = IDX_W'(15); end
      default: begin align_mask = ~ADDR_W'(3);    idx_mask = IDX_W'(31); end
    endcase
    phys_o    = byte_addr & align_mask;
    bit_idx_o = alias_i[IDX_W+1:2] & idx_mask;
    size_ok_o = size_valid(size_i);
  end
endmodule

// File: rtl/bb_bit_lane.sv
module bb_bit_lane #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              set_i,
  output logic              bit_o,
  output logic [DATA_W-1:0] data_o
);
  assign bit_o = data_i[idx_i];

  for (genvar g = 0; g < DATA_W; g++) begin : g_lane
    assign data_o[g] = (idx_i == IDX_W'(g)) ? set_i : data_i[g];
  end
endmodule

// File: rtl/bb_ctrl.sv
module bb_ctrl import bb_pkg::*; (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_valid_i,
  input  logic req_write_i,
  input  logic size_ok_i,
  input  logic mem_rvalid_i,
  input  logic mem_err_i,
  output logic req_ready_o,
  output logic accept_o,
  output logic fetch_ok_o,
  output logic is_write_o,
  output logic mem_req_o,
  output logic mem_we_o,
  output logic rsp_valid_o,
  output logic rsp_err_o
);
  bb_state_e state_q, state_d;
  logic      write_q, err_q;

  assign req_ready_o = state_q == ST_IDLE;
  assign accept_o    = req_ready_o && req_valid_i;
  assign fetch_ok_o  = state_q == ST_FETCH && mem_rvalid_i && !mem_err_i;
  assign is_write_o  = write_q;
  assign mem_req_o   = state_q == ST_FETCH || state_q == ST_STORE;
  assign mem_we_o    = state_q == ST_STORE;
  assign rsp_valid_o = state_q == ST_RESP;
  assign rsp_err_o   = err_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (req_valid_i) state_d = size_ok_i ? ST_FETCH : ST_RESP;
      ST_FETCH: if (mem_rvalid_i)
                  state_d = (!mem_err_i && write_q) ? ST_STORE : ST_RESP;
      ST_STORE: if (mem_rvalid_i) state_d = ST_RESP;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      write_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept_o) begin
        write_q <= req_write_i;
        err_q   <= !size_ok_i;
      end else if (mem_req_o && mem_rvalid_i) begin
        err_q   <= mem_err_i;
      end
    end
  end

  a_r7_idle_no_mem: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !mem_req_o);
  a_r7_hold_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rvalid_i |=> mem_req_o && $stable(mem_we_o));
  a_r7_rsp_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o && req_ready_o);
  a_r6_no_wb_after_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_o) |-> $past(mem_rvalid_i && !mem_err_i));
  a_r8_bad_size_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o && !size_ok_i |=> rsp_valid_o && rsp_err_o);
endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge import bb_pkg::*; #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned WIN_W  = 25,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h2000_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [1:0]        req_size_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic              rsp_err_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [1:0]        mem_size_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_rvalid_i,
  input  logic              mem_err_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  localparam int unsigned IDX_W = $clog2(DATA_W);

  logic              accept, fetch_ok, is_write, size_ok, sel_bit;
  logic [ADDR_W-1:0] phys, addr_q;
  logic [IDX_W-1:0]  idx, idx_q;
  logic [1:0]        size_q;
  logic              set_q, rbit_q;
  logic [DATA_W-1:0] merged, wdata_q;

  bb_addr_map #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .WIN_W(WIN_W), .IDX_W(IDX_W)) u_map (
    .alias_i(req_addr_i), .size_i(req_size_i),
    .phys_o(phys), .bit_idx_o(idx), .size_ok_o(size_ok)
  );

  bb_ctrl u_ctrl (
    .clk_i, .rst_ni, .req_valid_i, .req_write_i,
    .size_ok_i(size_ok), .mem_rvalid_i, .mem_err_i,
    .req_ready_o, .accept_o(accept), .fetch_ok_o(fetch_ok), .is_write_o(is_write),
    .mem_req_o, .mem_we_o, .rsp_valid_o, .rsp_err_o
  );

  bb_bit_lane #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_lane (
    .data_i(mem_rdata_i), .idx_i(idx_q), .set_i(set_q),
    .bit_o(sel_bit), .data_o(merged)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      size_q  <= '0;
      idx_q   <= '0;
      set_q   <= 1'b0;
      rbit_q  <= 1'b0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q <= phys;
      size_q <= req_size_i;
      idx_q  <= idx;
      set_q  <= req_wdata_i[0];
      rbit_q <= 1'b0;
    end else if (fetch_ok) begin
      wdata_q <= merged;
      rbit_q  <= sel_bit && !is_write;
    end
  end

  assign mem_addr_o  = addr_q;
  assign mem_size_o  = size_q;
  assign mem_wdata_o = wdata_q;
  assign rsp_rdata_o = DATA_W'(rbit_q);

  a_r1_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_size_o == 2'd0) || (mem_size_o == 2'd1 && !mem_addr_o[0]) ||
                  (mem_size_o == 2'd2 && mem_addr_o[1:0] == 2'b00));
  a_r4_one_bit_changed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_ok && is_write |=> $countones(mem_wdata_o ^ $past(mem_rdata_i)) <= 1);
  a_r4_target_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_wdata_o[idx_q] == set_q);
  a_r3_read_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && (rsp_err_o || is_write) |-> rsp_rdata_o == '0);
endmodule

// File: tb/sim_bitband_bridge.sv
`timescale 1ns/1ps
module sim_bitband_bridge;
  localparam logic [31:0] BASE = 32'h2000_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        req_valid = 0, req_ready, req_write = 0;
  logic [31:0] req_addr = 0, req_wdata = 0;
  logic [1:0]  req_size = 0;
  logic        rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic        mem_req, mem_we, mem_rvalid, mem_err;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [1:0]  mem_size;

  bitband_bridge u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_size_i(req_size), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_err_o(rsp_err), .rsp_rdata_o(rsp_rdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_size_o(mem_size), .mem_wdata_o(mem_wdata),
    .mem_rvalid_i(mem_rvalid), .mem_err_i(mem_err), .mem_rdata_i(mem_rdata)
  );

  // behavioural memory: 64 bytes, little-endian, one wait cycle
  logic [7:0]  mem [64];
  logic [1:0]  ms;
  logic        inj_err = 0;
  int          n_req, n_wr;
  logic [31:0] last_addr;

  function automatic logic [31:0] fetch(input logic [31:0] a, input logic [1:0] s);
    logic [31:0] r = '0;
    for (int k = 0; k < 4; k++)
      if (k < (1 << s)) r[8*k +: 8] = mem[(int'(a[5:0]) + k) % 64];
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms <= 0; mem_rvalid <= 0; mem_err <= 0; mem_rdata <= 0;
      n_req <= 0; n_wr <= 0; last_addr <= 0;
    end else begin
      mem_rvalid <= 0; mem_err <= 0;
      case (ms)
        2'd0: if (mem_req) ms <= 1;
        2'd1: begin
          ms <= 2; mem_rvalid <= 1; last_addr <= mem_addr; n_req <= n_req + 1;
          if (mem_we) begin
            n_wr <= n_wr + 1;
            for (int k = 0; k < 4; k++)
              if (k < (1 << mem_size)) mem[(int'(mem_addr[5:0]) + k) % 64] <= mem_wdata[8*k +: 8];
          end else begin
            mem_err <= inj_err;
            mem_rdata <= fetch(mem_addr, mem_size);
          end
        end
        default: ms <= 0;
      endcase
    end
  end

  int errors = 0, checks = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic txn(input bit we, input logic [31:0] a, input logic [1:0] s, input bit wb,
                     output logic [31:0] rd, output logic er);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = we; req_addr = a; req_size = s;
    req_wdata = {31'h7FFF_FFFF ^ {31{wb}}, wb};  // upper bits junk
    @(negedge clk);
    req_valid = 0;
    chk(req_ready == 1'b0, "R7 busy after accept", 32'(req_ready), 0);
    while (!rsp_valid) @(negedge clk);
    rd = rsp_rdata; er = rsp_err;
  endtask

  function automatic logic [31:0] exp_addr(input logic [31:0] a, input logic [1:0] s);
    logic [31:0] p = BASE | {12'h0, a[24:5]};
    return p & ~((32'd1 << s) - 1);
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, a, ea;
    logic        er, eb;
    logic [7:0]  snap [64];
    int          r0, w0;
    for (int i = 0; i < 64; i++) mem[i] = 8'(i * 37 + 11);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1 && mem_req == 0 && rsp_valid == 0, "R9 reset state",
        {29'h0, req_ready, mem_req, rsp_valid}, 32'h4);

    // read sweep: every bit of bytes 0..15 at every size
    for (int s = 0; s < 3; s++)
      for (int b = 0; b < 16; b++)
        for (int t = 0; t < 8; t++) begin
          a = 32'h2200_0000 | 32'((b << 5) | (t << 2)) | (32'(s) << 28);
          txn(0, a, 2'(s), 0, rd, er);
          eb = mem[b][t];
          chk(rd == {31'h0, eb} && er == 0, "R3/R2 read bit", rd, {31'h0, eb});
          chk(last_addr == exp_addr(a, 2'(s)), "R1 read address", last_addr, exp_addr(a, 2'(s)));
        end

    // top of window, upper alias bits ignored
    for (int s = 0; s < 3; s++) begin
      a = 32'hFBFF_FFFC;
      txn(0, a, 2'(s), 0, rd, er);
      chk(last_addr == exp_addr(a, 2'(s)), "R1 window top address", last_addr, exp_addr(a, 2'(s)));
      chk(rd == {31'h0, mem[63][7]}, "R2 window top bit", rd, {31'h0, mem[63][7]});
    end

    // write sweep: read-modify-write of every bit
    for (int s = 0; s < 3; s++)
      for (int b = 0; b < 16; b++)
        for (int t = 0; t < 8; t++) begin
          for (int i = 0; i < 64; i++) snap[i] = mem[i];
          eb = 1'((b + t + s) & 1);
          snap[b][t] = eb;
          r0 = n_req; w0 = n_wr;
          a = 32'h2200_0000 | 32'((b << 5) | (t << 2));
          txn(1, a, 2'(s), eb, rd, er);
          for (int i = 0; i < 64; i++)
            chk(mem[i] == snap[i], "R4/R5 memory after write", 32'(mem[i]), 32'(snap[i]));
          chk(n_wr == w0 + 1 && n_req == r0 + 2, "R4 one read one write",
              32'(n_req - r0), 32'd2);
          chk(er == 0 && rd == 0, "R4 write response", rd, 0);
          chk(last_addr == exp_addr(a, 2'(s)), "R4 write-back address", last_addr, exp_addr(a, 2'(s)));
        end

    // read error aborts without write-back
    inj_err = 1;
    for (int s = 0; s < 3; s++) begin
      for (int i = 0; i < 64; i++) snap[i] = mem[i];
      w0 = n_wr;
      txn(1, 32'h2200_0124, 2'(s), ~mem[9][1], rd, er);
      chk(er == 1 && rd == 0, "R6 write error response", {31'h0, er}, 1);
      chk(n_wr == w0, "R6 no write-back", 32'(n_wr), 32'(w0));
      chk(mem[9] == snap[9], "R6 memory unchanged", 32'(mem[9]), 32'(snap[9]));
      txn(0, 32'h2200_0124, 2'(s), 0, rd, er);
      chk(er == 1 && rd == 0, "R6 read error response", rd, 0);
    end
    inj_err = 0;

    // illegal size code
    for (int w = 0; w < 2; w++) begin
      r0 = n_req;
      txn(w[0], 32'h2200_0040, 2'd3, 1, rd, er);
      chk(er == 1, "R8 size 3 error", {31'h0, er}, 1);
      @(negedge clk); @(negedge clk);
      chk(n_req == r0, "R8 no memory access", 32'(n_req), 32'(r0));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule